// File: doc/BRIEF.md
# Rising-Edge Interrupt Controller with Access-Side-Effect Control

This block generates one level-sensitive interrupt request for a two-group digital I/O device. A single input pin in each group can cause an interrupt. Both pins are synchronised into the local clock domain. Only a low-to-high transition counts as an event. Any event sets one shared pending flag.

The host controls the request entirely through the side effects of bus accesses to two fixed offsets in the device window. The data carried by those accesses is irrelevant. A write to the arm offset turns interrupt generation on. A read of that same offset turns it off. A write to the clear offset drops the pending flag.

The request output is high whenever the flag is pending and generation is armed. The block does not drive read data and holds no port data registers.

Top module: `edge_irq_ctl`

## Requirements
- R1: After reset the request output is low, generation is disarmed and nothing is pending. While disarmed after a reset, a rising pin edge does not set the pending flag.
- R2: A write strobe with the address equal to 0xB arms generation from the next clock edge onward.
- R3: A read strobe with the address equal to 0xB disarms generation at the next clock edge. A request that was high drops at that edge.
- R4: While armed, a rising edge on either monitored pin raises the request at the third clock edge after the pin is first sampled high. The request is still low after the second such edge.
- R5: A rising edge that is detected while disarmed leaves the pending flag clear, so arming later does not raise the request.
- R6: A pin that stays high, or a pin that falls, never sets the pending flag.
- R7: A write strobe with the address equal to 0xF clears the pending flag. The request is low from the next clock edge.
- R8: When a detected edge and a clear write fall in the same cycle, the edge takes priority and the flag stays pending.
- R9: Disarming masks the request but keeps the pending flag. Arming again without a clear raises the request at the next edge.
- R10: A write to any offset other than 0xB or 0xF, a read of any offset other than 0xB, and a repeated arm write all leave the request unchanged.
- R11: If a read strobe and a write strobe to 0xB arrive in the same cycle, disarm takes priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pin | input | NUM_SRC (2) | Monitored pins, one per group, asynchronous to clk |
| bus_wr | input | 1 | Bus write strobe, one cycle per access |
| bus_rd | input | 1 | Bus read strobe, one cycle per access |
| bus_addr | input | ADDR_W (4) | Offset in the device window |
| irq_req | output | 1 | Level interrupt request |

## Verification
A bus access takes effect at the first clock edge that samples its strobe. The request therefore changes one edge after the access. A pin change passes through two synchroniser flops and an edge register before the flag is set, so the request changes at the third edge after the pin is first sampled.

The reference model keeps a delay line of pin samples and applies bus effects at the sampling edge. Its comparison runs 1 ns after every rising clock edge. The directed checks advance whole falling-edge steps and test the request at each step. This catches one-cycle-early and one-cycle-late responses, including the edge-versus-clear collision cycle.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

  typedef struct packed {
    logic arm;
    logic disarm;
    logic clear;
  } eirq_evt_t;

  // Disarm outranks arm when both happen in one cycle.
  function automatic logic eirq_next_enable(input logic en, input eirq_evt_t e);
    if (e.disarm)   return 1'b0;
    else if (e.arm) return 1'b1;
    else            return en;
  endfunction

  // A captured edge outranks a clear in the same cycle.
  function automatic logic eirq_next_pending(input logic pend, input logic en,
                                             input logic rise, input logic clr);
    if (rise && en) return 1'b1;
    else if (clr)   return 1'b0;
    else            return pend;
  endfunction

endpackage

// File: rtl/eirq_pin_edge.sv
module eirq_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      last_q <= synced;
    end
  end

  assign rise_o = synced & ~last_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R6

endmodule

// File: rtl/eirq_bus_decode.sv
module eirq_bus_decode
  import eirq_pkg::*;
#(
  parameter int                ADDR_W  = 4,
  parameter logic [ADDR_W-1:0] ARM_OFF = 'hB,
  parameter logic [ADDR_W-1:0] CLR_OFF = 'hF
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output eirq_evt_t         evt_o
);
  logic hit_arm;
  logic hit_clr;

  assign hit_arm      = (bus_addr == ARM_OFF);
  assign hit_clr      = (bus_addr == CLR_OFF);
  assign evt_o.arm    = bus_wr & hit_arm;
  assign evt_o.disarm = bus_rd & hit_arm;
  assign evt_o.clear  = bus_wr & hit_clr;

endmodule

// File: rtl/eirq_flags.sv
module eirq_flags
  import eirq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  eirq_evt_t evt_i,
  input  logic      rise_i,
  output logic      enable_o,
  output logic      pending_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_o  <= 1'b0;
      pending_o <= 1'b0;
    end else begin
      enable_o  <= eirq_next_enable(enable_o, evt_i);
      pending_o <= eirq_next_pending(pending_o, enable_o, rise_i, evt_i.clear);
    end
  end

  AST_ARM_SETS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i.arm && !evt_i.disarm) |=> enable_o); // R2
  AST_DISARM_CLRS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i.disarm |=> !enable_o); // R3
  AST_RISE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && enable_o) |=> pending_o); // R4
  AST_NO_PEND_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_o && !pending_o) |=> !pending_o); // R5
  AST_CLR_DROPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i.clear && !(rise_i && enable_o)) |=> !pending_o); // R7
  AST_EDGE_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i.clear && rise_i && enable_o) |=> pending_o); // R8
  AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_i.arm && !evt_i.disarm) |=> $stable(enable_o)); // R10

endmodule

// File: rtl/edge_irq_ctl.sv
module edge_irq_ctl
  import eirq_pkg::*;
#(
  parameter int                NUM_SRC     = 2,
  parameter int                SYNC_STAGES = 2,
  parameter int                ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] ARM_OFF     = 'hB,
  parameter logic [ADDR_W-1:0] CLR_OFF     = 'hF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_pin,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  output logic               irq_req
);
  logic [NUM_SRC-1:0] rise_vec;
  logic               any_rise;
  eirq_evt_t          bus_evt;
  logic               irq_en;
  logic               irq_pend;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    eirq_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (src_pin[g]),
      .rise_o (rise_vec[g])
    );
  end

  assign any_rise = |rise_vec;

  eirq_bus_decode #(
    .ADDR_W  (ADDR_W),
    .ARM_OFF (ARM_OFF),
    .CLR_OFF (CLR_OFF)
  ) u_dec (
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .evt_o    (bus_evt)
  );

  eirq_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (bus_evt),
    .rise_i    (any_rise),
    .enable_o  (irq_en),
    .pending_o (irq_pend)
  );

  assign irq_req = irq_pend & irq_en;

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> ($past(any_rise) || $past(bus_evt.arm))); // R9

endmodule

// File: tb/edge_irq_ctl_tb.sv
module edge_irq_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] src_pin;
  logic       bus_wr;
  logic       bus_rd;
  logic [3:0] bus_addr;
  logic       irq_req;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  localparam logic [3:0] A_ARM = 4'hB;
  localparam logic [3:0] A_CLR = 4'hF;

  always #2.5 clk = ~clk;

  edge_irq_ctl dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_pin  (src_pin),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .irq_req  (irq_req)
  );

  // Reference model: pin-sample delay line plus two flags.
  logic [1:0] pin_hist [4];
  logic       m_en;
  logic       m_pend;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) pin_hist[k] = 2'b00;
      m_en   = 1'b0;
      m_pend = 1'b0;
    end else begin
      logic edge_seen;
      for (int k = 3; k > 0; k--) pin_hist[k] = pin_hist[k-1];
      pin_hist[0] = src_pin;
      edge_seen = |(pin_hist[2] & ~pin_hist[3]);
      if (edge_seen && m_en) m_pend = 1'b1;
      else if (bus_wr && bus_addr == A_CLR) m_pend = 1'b0;
      if (bus_rd && bus_addr == A_ARM) m_en = 1'b0;
      else if (bus_wr && bus_addr == A_ARM) m_en = 1'b1;
    end
    #1;
    if (!done) begin
      vectors++;
      if (irq_req !== (m_pend & m_en)) begin
        fails++;
        $display("FAIL model-compare (R9) t=%0t irq_req=%0b expected %0b",
                 $time, irq_req, m_pend & m_en);
      end
    end
  end

  task automatic expect_irq(input string tag, input logic exp);
    vectors++;
    if (irq_req !== exp) begin
      fails++;
      $display("FAIL %s irq_req=%0b expected %0b", tag, irq_req, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic access(input logic w, input logic r, input logic [3:0] a);
    bus_wr = w; bus_rd = r; bus_addr = a;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 4'h0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (R1) irq_req=%0b expected completion", irq_req);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_pin = 2'b00; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 4'h0;
    step(4);
    expect_irq("R1 reset state", 1'b0);
    rst_n = 1'b1;

    src_pin[0] = 1'b1; step(5);
    expect_irq("R1 edge after reset ignored", 1'b0);
    src_pin[0] = 1'b0; step(3);
    access(1'b1, 1'b0, A_ARM);
    expect_irq("R5 no stale pending on arm", 1'b0);

    src_pin[1] = 1'b1; step(2);
    expect_irq("R4 not yet after two edges", 1'b0);
    step(1);
    expect_irq("R4 raised at third edge", 1'b1);

    access(1'b1, 1'b0, A_CLR);
    expect_irq("R7 clear drops request", 1'b0);
    step(4);
    expect_irq("R6 steady high ignored", 1'b0);
    src_pin[1] = 1'b0; step(5);
    expect_irq("R6 falling edge ignored", 1'b0);

    src_pin[0] = 1'b1; step(3);
    expect_irq("R4 source 0 raises", 1'b1);
    access(1'b0, 1'b1, A_ARM);
    expect_irq("R3 read disarms", 1'b0);
    access(1'b1, 1'b0, A_ARM);
    expect_irq("R9 pending kept across disarm", 1'b1);

    for (int a = 0; a < 16; a++) begin
      if (a != 4'hB && a != 4'hF) begin
        access(1'b1, 1'b0, 4'(a));
        expect_irq("R10 unrelated write", 1'b1);
      end
      if (a != 4'hB) begin
        access(1'b0, 1'b1, 4'(a));
        expect_irq("R10 unrelated read", 1'b1);
      end
    end
    access(1'b1, 1'b0, A_ARM);
    expect_irq("R10 repeated arm", 1'b1);
    access(1'b1, 1'b0, A_CLR);
    expect_irq("R7 clear again", 1'b0);

    src_pin[0] = 1'b0; step(3);
    src_pin[0] = 1'b1; step(3);
    expect_irq("R4 re-edge", 1'b1);
    access(1'b1, 1'b1, A_ARM);
    expect_irq("R11 disarm wins", 1'b0);
    access(1'b1, 1'b0, A_ARM);
    expect_irq("R11 pending kept", 1'b1);
    access(1'b1, 1'b0, A_CLR);
    expect_irq("R7 clear", 1'b0);

    src_pin[1] = 1'b1; step(2);
    expect_irq("R8 before collision", 1'b0);
    access(1'b1, 1'b0, A_CLR);
    expect_irq("R8 edge beats clear", 1'b1);
    access(1'b1, 1'b0, A_CLR);
    expect_irq("R7 clear after collision", 1'b0);

    access(1'b0, 1'b1, A_ARM);
    src_pin[0] = 1'b0; step(3);
    src_pin[0] = 1'b1; step(4);
    access(1'b1, 1'b0, A_ARM);
    expect_irq("R5 edge while disarmed lost", 1'b0);

    src_pin[1] = 1'b0; step(3);
    src_pin[1] = 1'b1; step(3);
    expect_irq("R4 before reset", 1'b1);
    rst_n = 1'b0; step(1);
    expect_irq("R1 reset clears request", 1'b0);
    step(2); rst_n = 1'b1; step(4);
    access(1'b1, 1'b0, A_ARM);
    expect_irq("R1 reset disarmed", 1'b0);

    src_pin = 2'b00; step(4);
    for (int c = 0; c < 3000; c++) begin
      logic [3:0] a;
      if ($urandom % 8 == 0) src_pin[$urandom % 2] = ~src_pin[$urandom % 2];
      case ($urandom % 3)
        0:       a = A_ARM;
        1:       a = A_CLR;
        default: a = 4'($urandom % 16);
      endcase
      bus_addr = a;
      bus_wr   = ($urandom % 4 == 0);
      bus_rd   = ($urandom % 5 == 0);
      @(negedge clk);
    end
    bus_wr = 1'b0; bus_rd = 1'b0;
    step(2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule